// File: doc/BRIEF.md
# Hardware Metadata Query Responder

This block answers queries about the capabilities of the attached processor. A host sends one 64-bit request word over a valid/ready input. The block checks that the word is a metadata request and reads which item is wanted. It then returns 64-bit answer words over a valid/ready output. A qubit-count or depth query gets a single answer word. A native-gate query gets a stream of words, one for each entry of a small internal gate table. Each word carries the gate's opcode and its duration in picoseconds.

Two other item codes, connectivity and error rate, are served by neighbouring streaming blocks. The responder hands those requests on, unchanged, over a separate valid/ready side port. Malformed requests are dropped and flagged with a single-cycle error pulse. The scalar values and the gate table are loaded through a small write-only configuration port. That port only takes effect while the block is idle.

Top module: `metadata_responder`

## Requirements
- R1: `reqReady` is high only while no answer word and no forwarded request is pending. A new request is accepted only after the previous answer stream or forward has completed.
- R2: A request is a word with opcode 8 in bits [63:52] and an item code in bits [51:36]. The item code 1 returns one word with 3'b001 in bits [63:61] and the configured qubit count, zero-extended, in bits [60:0].
- R3: The item code 2 returns one word with 3'b010 in bits [63:61] and the configured maximum depth, zero-extended, in bits [60:0].
- R4: The item code 3 returns one word per configured gate, in table order starting at entry 0. Each word has 3'b011 in [63:61], the final flag in [60], the gate index in [59:56], the gate opcode in [55:44] and the gate time in [43:0].
- R5: The final flag (bit 60) is set only on the word for the last configured gate. Once that word is consumed, no further answer word follows.
- R6: A request whose opcode is not 8, or whose item code is outside 1..5, is dropped. `errPulse` is high for exactly the one cycle after acceptance. No answer word and no forward result from it.
- R7: Item codes 4 and 5 are presented unchanged on `fwdWord` with `fwdValid`. The word is held stable until `fwdReady` is seen.
- R8: While `rspValid` is high and `rspReady` is low, `rspWord` holds its value.
- R9: A configuration write is decoded from `cfgSel`: 0 is the qubit count (data bits [QUBIT_W-1:0]), 1 is the maximum depth (data bits [DEPTH_W-1:0]), 2 is the gate count and 3 is the gate entry `cfgIdx`. A gate entry takes its opcode from data bits [55:44] and its time from bits [43:0]. A write that would make a qubit count, depth or gate time zero is ignored.
- R10: A gate-count write is applied only for values 1 to GATES (16 by default); any other value is ignored.
- R11: Configuration writes made while an answer or forward is pending are ignored.
- R12: After reset the block is idle with `reqReady` high and all outputs quiet. The qubit count, depth and gate count are 1. Every gate entry holds opcode 0 and time 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request word valid |
| reqReady | output | 1 | Block can take a request |
| reqWord | input | 64 | Request word |
| rspValid | output | 1 | Answer word valid |
| rspReady | input | 1 | Consumer takes the answer word |
| rspWord | output | 64 | Answer word |
| fwdValid | output | 1 | Forwarded request valid |
| fwdReady | input | 1 | Streaming block takes the forwarded request |
| fwdWord | output | 64 | Forwarded request word |
| errPulse | output | 1 | One-cycle pulse on a dropped request |
| cfgWe | input | 1 | Configuration write enable |
| cfgSel | input | 2 | Configuration target select |
| cfgIdx | input | 4 | Gate table entry for a gate write |
| cfgData | input | 64 | Configuration write data |

## Verification
The bench aims at the end of the gate stream. It checks a single-entry table and a completely full table of 16 entries. A design with an off-by-one in its last-gate compare would send a missing or extra word there, or put the final flag on the wrong word. It stalls the consumer in the middle of a stream. A design that moved its index without a handshake would skip or repeat gates. Writes that would set a count or time to zero, and writes made while an answer is pending, are each followed by a query. A design that took such a write would then report a changed or zero value. Opcodes other than 8 and item codes 0 and 6 are sent to show that a bad request gives a pulse of exactly one cycle and no output at all.

// File: rtl/meta_pkg.sv
package meta_pkg;
  localparam int WORD_W = 64;
  localparam int OPC_W  = 12;
  localparam int TIME_W = 44;
  localparam int GIDX_W = 4;
  localparam int VAL_W  = 61;
  localparam logic [OPC_W-1:0] META_OPC = 12'd8;

  typedef enum logic [2:0] {
    ITEM_NONE   = 3'd0,
    ITEM_QUBITS = 3'd1,
    ITEM_DEPTH  = 3'd2,
    ITEM_GATES  = 3'd3,
    ITEM_CONN   = 3'd4,
    ITEM_ERRS   = 3'd5
  } item_e;

  typedef enum logic [1:0] {
    CFG_QUBITS = 2'd0,
    CFG_DEPTH  = 2'd1,
    CFG_COUNT  = 2'd2,
    CFG_GATE   = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    S_IDLE, S_SINGLE, S_STREAM, S_FWD
  } state_e;

  // control -> datapath strobes
  typedef struct packed {
    logic latchReq;
    logic clrIdx;
    logic incIdx;
    logic cfgEn;
  } strobe_t;

  // head = request bits [63:36]: opcode then item argument
  function automatic item_e decodeHead(input logic [27:0] head);
    if (head[27:16] != META_OPC) return ITEM_NONE;
    if (head[15:0] >= 16'd1 && head[15:0] <= 16'd5) return item_e'(head[2:0]);
    return ITEM_NONE;
  endfunction
endpackage

// File: rtl/meta_ctrl.sv
module meta_ctrl
  import meta_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [27:0] reqHead,
  input  logic        rspReady,
  input  logic        fwdReady,
  input  logic        lastGate,
  output logic        reqReady,
  output logic        rspValid,
  output logic        fwdValid,
  output logic        errPulse,
  output item_e       curItem,
  output strobe_t     strobe
);
  state_e stateQ, stateD;
  item_e  reqItem;
  logic   take;

  always_comb begin
    reqItem = decodeHead(reqHead);
    take    = reqValid && (stateQ == S_IDLE);
    stateD  = stateQ;
    case (stateQ)
      S_IDLE: if (take) begin
        case (reqItem)
          ITEM_QUBITS, ITEM_DEPTH: stateD = S_SINGLE;
          ITEM_GATES:              stateD = S_STREAM;
          ITEM_CONN, ITEM_ERRS:    stateD = S_FWD;
          default:                 stateD = S_IDLE;
        endcase
      end
      S_SINGLE: if (rspReady) stateD = S_IDLE;
      S_STREAM: if (rspReady && lastGate) stateD = S_IDLE;
      S_FWD:    if (fwdReady) stateD = S_IDLE;
      default:  stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= S_IDLE;
      curItem  <= ITEM_NONE;
      errPulse <= 1'b0;
    end else begin
      stateQ   <= stateD;
      errPulse <= take && (reqItem == ITEM_NONE);
      if (take) curItem <= reqItem;
    end
  end

  assign reqReady = (stateQ == S_IDLE);
  assign rspValid = (stateQ == S_SINGLE) || (stateQ == S_STREAM);
  assign fwdValid = (stateQ == S_FWD);

  always_comb begin
    strobe.latchReq = take;
    strobe.clrIdx   = take;
    strobe.incIdx   = (stateQ == S_STREAM) && rspReady && !lastGate;
    strobe.cfgEn    = (stateQ == S_IDLE);
  end
endmodule

// File: rtl/meta_dpath.sv
module meta_dpath
  import meta_pkg::*;
#(
  parameter int GATES      = 16,
  parameter int QUBIT_W    = 16,
  parameter int DEPTH_W    = 32,
  parameter int RST_QUBITS = 1,
  parameter int RST_DEPTH  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  item_e             curItem,
  input  logic [WORD_W-1:0] reqWord,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [3:0]        cfgIdx,
  input  logic [WORD_W-1:0] cfgData,
  output logic              lastGate,
  output logic [WORD_W-1:0] rspWord,
  output logic [WORD_W-1:0] fwdWord
);
  localparam int CNT_W = $clog2(GATES + 1);

  logic [QUBIT_W-1:0] qubitsQ;
  logic [DEPTH_W-1:0] depthQ;
  logic [CNT_W-1:0]   countQ;
  logic [GIDX_W-1:0]  idxQ;
  logic [WORD_W-1:0]  reqQ;
  logic [OPC_W-1:0]   opTab   [GATES];
  logic [TIME_W-1:0]  timeTab [GATES];
  logic               wrEn;

  assign wrEn = cfgWe && strobe.cfgEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qubitsQ <= QUBIT_W'(RST_QUBITS);
      depthQ  <= DEPTH_W'(RST_DEPTH);
      countQ  <= CNT_W'(1);
      idxQ    <= '0;
      reqQ    <= '0;
    end else begin
      if (wrEn && cfgSel == CFG_QUBITS && cfgData[QUBIT_W-1:0] != '0)
        qubitsQ <= cfgData[QUBIT_W-1:0];
      if (wrEn && cfgSel == CFG_DEPTH && cfgData[DEPTH_W-1:0] != '0)
        depthQ <= cfgData[DEPTH_W-1:0];
      if (wrEn && cfgSel == CFG_COUNT && cfgData != '0 && cfgData <= 64'(GATES))
        countQ <= cfgData[CNT_W-1:0];
      if (strobe.latchReq) reqQ <= reqWord;
      if (strobe.clrIdx) idxQ <= '0;
      else if (strobe.incIdx) idxQ <= idxQ + 1'b1;
    end
  end

  for (genvar g = 0; g < GATES; g++) begin : gEntry
    logic [OPC_W-1:0]  opQ;
    logic [TIME_W-1:0] timeQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        opQ   <= '0;
        timeQ <= TIME_W'(1);
      end else if (wrEn && cfgSel == CFG_GATE && cfgIdx == 4'(g)
                   && cfgData[TIME_W-1:0] != '0) begin
        opQ   <= cfgData[55:44];
        timeQ <= cfgData[TIME_W-1:0];
      end
    end
    assign opTab[g]   = opQ;
    assign timeTab[g] = timeQ;
  end

  assign lastGate = (CNT_W'(idxQ) == countQ - CNT_W'(1));

  always_comb begin
    case (curItem)
      ITEM_QUBITS: rspWord = {ITEM_QUBITS, VAL_W'(qubitsQ)};
      ITEM_DEPTH:  rspWord = {ITEM_DEPTH, VAL_W'(depthQ)};
      ITEM_GATES:  rspWord = {ITEM_GATES, lastGate, idxQ, opTab[idxQ], timeTab[idxQ]};
      default:     rspWord = '0;
    endcase
  end

  assign fwdWord = reqQ;
endmodule

// File: rtl/metadata_responder.sv
module metadata_responder
  import meta_pkg::*;
#(
  parameter int GATES      = 16,
  parameter int QUBIT_W    = 16,
  parameter int DEPTH_W    = 32,
  parameter int RST_QUBITS = 1,
  parameter int RST_DEPTH  = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [63:0] reqWord,
  output logic        rspValid,
  input  logic        rspReady,
  output logic [63:0] rspWord,
  output logic        fwdValid,
  input  logic        fwdReady,
  output logic [63:0] fwdWord,
  output logic        errPulse,
  input  logic        cfgWe,
  input  logic [1:0]  cfgSel,
  input  logic [3:0]  cfgIdx,
  input  logic [63:0] cfgData
);
  strobe_t strobe;
  item_e   curItem;
  logic    lastGate;

  meta_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqHead(reqWord[63:36]),
    .rspReady(rspReady), .fwdReady(fwdReady), .lastGate(lastGate),
    .reqReady(reqReady), .rspValid(rspValid), .fwdValid(fwdValid),
    .errPulse(errPulse), .curItem(curItem), .strobe(strobe)
  );

  meta_dpath #(
    .GATES(GATES), .QUBIT_W(QUBIT_W), .DEPTH_W(DEPTH_W),
    .RST_QUBITS(RST_QUBITS), .RST_DEPTH(RST_DEPTH)
  ) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curItem(curItem),
    .reqWord(reqWord), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgIdx(cfgIdx),
    .cfgData(cfgData), .lastGate(lastGate), .rspWord(rspWord), .fwdWord(fwdWord)
  );
endmodule

// File: rtl/metadata_responder_chk.sv
module metadata_responder_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqReady,
  input logic        rspValid,
  input logic        rspReady,
  input logic [63:0] rspWord,
  input logic        fwdValid,
  input logic        fwdReady,
  input logic [63:0] fwdWord,
  input logic        errPulse
);
  a_r1_busy_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid || fwdValid) |-> !reqReady);

  a_r4_index_steps: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspReady && rspWord[63:61] == 3'd3 && !rspWord[60])
      |=> (rspValid && rspWord[59:56] == $past(rspWord[59:56]) + 4'd1));

  a_r5_final_ends: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspReady && rspWord[63:61] == 3'd3 && rspWord[60])
      |=> (!rspValid && reqReady));

  a_r6_err_single: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |=> !errPulse);

  a_r6_err_quiet: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> (!rspValid && !fwdValid));

  a_r7_fwd_hold: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && !fwdReady) |=> (fwdValid && $stable(fwdWord)));

  a_r7_fwd_item: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |-> (fwdWord[63:52] == 12'd8 &&
                  (fwdWord[51:36] == 16'd4 || fwdWord[51:36] == 16'd5)));

  a_r8_rsp_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspWord)));

  a_r9_scalar_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && (rspWord[63:61] == 3'd1 || rspWord[63:61] == 3'd2))
      |-> (rspWord[60:0] != '0));

  a_r9_time_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspWord[63:61] == 3'd3) |-> (rspWord[43:0] != '0));
endmodule

bind metadata_responder metadata_responder_chk uChk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rspValid(rspValid),
  .rspReady(rspReady), .rspWord(rspWord), .fwdValid(fwdValid),
  .fwdReady(fwdReady), .fwdWord(fwdWord), .errPulse(errPulse)
);

// File: tb/tb_metadata_responder.sv
`timescale 1ns/1ps
module tb_metadata_responder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [63:0] reqWord = '0;
  logic        rspValid;
  logic        rspReady = 1'b0;
  logic [63:0] rspWord;
  logic        fwdValid;
  logic        fwdReady = 1'b0;
  logic [63:0] fwdWord;
  logic        errPulse;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [3:0]  cfgIdx = '0;
  logic [63:0] cfgData = '0;

  int checks = 0;
  int failures = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  metadata_responder dut (.*);

  function automatic logic [63:0] mkReq(input logic [11:0] opc, input logic [15:0] arg,
                                        input logic [35:0] pad);
    return {opc, arg, pad};
  endfunction

  function automatic logic [63:0] gateWord(input logic fin, input logic [3:0] idx,
                                           input logic [11:0] op, input logic [43:0] tm);
    return {3'd3, fin, idx, op, tm};
  endfunction

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input logic [3:0] idx, input logic [63:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgIdx = idx; cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // drives a request at a negedge while idle; returns at the negedge after acceptance
  task automatic sendReq(input logic [63:0] w);
    @(negedge clk);
    reqValid = 1'b1; reqWord = w;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // samples the current answer word at a negedge and consumes it at the next edge
  task automatic takeRsp(output logic [63:0] w, output logic v);
    v = rspValid; w = rspWord;
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
  endtask

  task automatic querySingle(input logic [15:0] arg, input logic [63:0] exp, input string req);
    logic [63:0] w; logic v;
    sendReq(mkReq(12'd8, arg, 36'h0));
    takeRsp(w, v);
    check(v && w == exp, req, w, exp);
    check(!rspValid && reqReady, {req, " single word"}, {63'd0, rspValid}, 64'd0);
  endtask

  task automatic t_reset();
    check(reqReady && !rspValid && !fwdValid && !errPulse, "R12 idle outputs",
          {60'd0, reqReady, rspValid, fwdValid, errPulse}, 64'h8);
    querySingle(16'd1, {3'b001, 61'd1}, "R12 reset qubits");
    querySingle(16'd2, {3'b010, 61'd1}, "R12 reset depth");
    querySingle(16'd3, gateWord(1'b1, 4'd0, 12'd0, 44'd1), "R12 reset gate stream");
  endtask

  task automatic t_scalars();
    cfgWrite(2'd0, 4'd0, 64'd4);
    querySingle(16'd1, {3'b001, 61'd4}, "R2 qubit count");
    cfgWrite(2'd1, 4'd0, 64'd200);
    querySingle(16'd2, {3'b010, 61'd200}, "R3 depth");
    cfgWrite(2'd0, 4'd0, 64'd0);
    querySingle(16'd1, {3'b001, 61'd4}, "R9 zero qubit write ignored");
    cfgWrite(2'd1, 4'd0, 64'd0);
    querySingle(16'd2, {3'b010, 61'd200}, "R9 zero depth write ignored");
  endtask

  task automatic t_stream3();
    logic [63:0] w; logic v;
    logic [11:0] ops [3];
    logic [43:0] tms [3];
    ops[0] = 12'd10; ops[1] = 12'd30; ops[2] = 12'd60;
    tms[0] = 44'd16000; tms[1] = 44'd20000; tms[2] = 44'd28000;
    for (int i = 0; i < 3; i++) cfgWrite(2'd3, 4'(i), {8'd0, ops[i], tms[i]});
    cfgWrite(2'd2, 4'd0, 64'd3);
    cfgWrite(2'd3, 4'd1, {8'd0, 12'd99, 44'd0});   // zero time: ignored
    sendReq(mkReq(12'd8, 16'd3, 36'h0));
    w = rspWord;
    repeat (3) @(negedge clk);
    check(rspValid && rspWord == w, "R8 stalled word stable", rspWord, w);
    check(!reqReady, "R1 busy during stream", {63'd0, reqReady}, 64'd0);
    for (int i = 0; i < 3; i++) begin
      takeRsp(w, v);
      check(v && w == gateWord(i == 2, 4'(i), ops[i], tms[i]), "R4 gate word",
            w, gateWord(i == 2, 4'(i), ops[i], tms[i]));
    end
    check(!rspValid && reqReady, "R5 nothing after final", {63'd0, rspValid}, 64'd0);
  endtask

  task automatic t_full();
    logic [63:0] w; logic v;
    cfgWrite(2'd2, 4'd0, 64'd17);
    cfgWrite(2'd2, 4'd0, 64'd0);
    sendReq(mkReq(12'd8, 16'd3, 36'h0));
    for (int i = 0; i < 3; i++) takeRsp(w, v);
    check(!rspValid && w[60], "R10 bad counts ignored", w, gateWord(1'b1, 4'd2, 12'd60, 44'd28000));
    for (int i = 0; i < 16; i++) cfgWrite(2'd3, 4'(i), {8'd0, 12'(100 + i), 44'(5000 + i)});
    cfgWrite(2'd2, 4'd0, 64'd16);
    sendReq(mkReq(12'd8, 16'd3, 36'h0));
    for (int i = 0; i < 16; i++) begin
      takeRsp(w, v);
      check(v && w == gateWord(i == 15, 4'(i), 12'(100 + i), 44'(5000 + i)),
            "R5 full table word", w, gateWord(i == 15, 4'(i), 12'(100 + i), 44'(5000 + i)));
    end
    check(!rspValid, "R5 full table ends", {63'd0, rspValid}, 64'd0);
    cfgWrite(2'd2, 4'd0, 64'd1);
    querySingle(16'd3, gateWord(1'b1, 4'd0, 12'd100, 44'd5000), "R4 single-entry table");
  endtask

  task automatic badReq(input logic [63:0] req, input string tag);
    sendReq(req);
    check(errPulse && !rspValid && !fwdValid, {tag, " err pulse"},
          {61'd0, errPulse, rspValid, fwdValid}, 64'h4);
    @(negedge clk);
    check(!errPulse && !rspValid && !fwdValid && reqReady, {tag, " err cleared"},
          {61'd0, errPulse, rspValid, fwdValid}, 64'h0);
  endtask

  task automatic t_bad();
    badReq(mkReq(12'd9, 16'd1, 36'h0), "R6 opcode 9");
    badReq(mkReq(12'd8, 16'd0, 36'h0), "R6 item 0");
    badReq(mkReq(12'd8, 16'd6, 36'h0), "R6 item 6");
  endtask

  task automatic t_fwd();
    logic [63:0] req;
    req = mkReq(12'd8, 16'd4, 36'h8_0000_0003);
    sendReq(req);
    check(fwdValid && fwdWord == req && !rspValid, "R7 forward word", fwdWord, req);
    repeat (2) @(negedge clk);
    check(fwdValid && fwdWord == req && !reqReady, "R1 held forward", fwdWord, req);
    fwdReady = 1'b1;
    @(negedge clk);
    fwdReady = 1'b0;
    check(!fwdValid && reqReady, "R7 forward done", {63'd0, fwdValid}, 64'd0);
    req = mkReq(12'd8, 16'd5, 36'h2_0000_0000);
    sendReq(req);
    check(fwdValid && fwdWord == req, "R7 forward item 5", fwdWord, req);
    fwdReady = 1'b1;
    @(negedge clk);
    fwdReady = 1'b0;
  endtask

  task automatic t_busyCfg();
    logic [63:0] w; logic v;
    sendReq(mkReq(12'd8, 16'd1, 36'h0));
    cfgWrite(2'd0, 4'd0, 64'd9);
    check(!reqReady, "R1 not ready while pending", {63'd0, reqReady}, 64'd0);
    takeRsp(w, v);
    check(v && w == {3'b001, 61'd4}, "R11 pending answer unchanged", w, {3'b001, 61'd4});
    querySingle(16'd1, {3'b001, 61'd4}, "R11 busy write ignored");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_scalars();
    t_stream3();
    t_full();
    t_bad();
    t_fwd();
    t_busyCfg();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule